// File: doc/BRIEF.md
# Control Endpoint Stage Sequencer

This block follows a USB device controller's endpoint-zero control transfer through its stages. Each received SETUP packet arrives as an event carrying the decoded direction bit and the requested length. The sequencer then moves to an IN data stage, to an OUT data stage, or straight back to idle when the request has no data stage. It watches packet events to find the end of the data stage. At that point it pulses a status-stage trigger. Firmware can hold that pulse back with a delayed-status request. Firmware can also force a protocol stall, and only a new SETUP ends a stall.

The IN path has a separate wait stage. After the final IN packet is queued, the block stays in that stage until firmware reports that the packet has completed. On the OUT path, the block counts the bytes that remain. The data stage ends on a short packet or when the requested length has been reached.

A six-byte response store holds replies that the device answers locally. A six-byte reply needs all six entries, and a two-byte status reply uses the first two. Firmware writes the bytes by index and starts a read-out with a length. The bytes then leave on a valid/ready stream. The consumer may hold `rsp_ready` low for any number of cycles. While it does, `rsp_valid`, `rsp_data` and `rsp_last` stay unchanged. A byte is consumed only in a cycle where `rsp_valid` and `rsp_ready` are both high. Writes and starts are ignored until the last byte has been consumed.

Top module: `ep0_stage_seq`

## Requirements
- R1: After reset, `stage` is 1 (idle), `stall_en` is 0, `status_go` is 0 and `rsp_valid` is 0.
- R2: Stage codes are idle=1, IN data=2, OUT data=3, IN wait-for-completion=4, stall=5. A SETUP with nonzero length and direction bit 1 moves to 2. A SETUP with nonzero length and direction bit 0 moves to 3. A SETUP with zero length leaves the stage at 1 and requests the status stage. Every change becomes visible on the clock edge that samples the event.
- R3: In stage 2, an IN packet event marked last moves to 4, and an IN packet event not marked last keeps 2. In stage 4, the completion event moves to 1 and requests the status stage.
- R4: In stage 3, an OUT packet event ends the data stage, moving to 1 and requesting the status stage, if its length is below MAXP or if it covers the bytes still outstanding from the SETUP length. Otherwise the stage stays 3 and the outstanding count drops by that length.
- R5: A stall request in any stage moves to 5 and raises `stall_en`. Stage 5 persists until a SETUP arrives.
- R6: A SETUP in any stage, including 5, aborts the transfer and is decoded as in R2. It wins over a stall request in the same cycle, and it discards any pending status request.
- R7: While the delayed-status flag is set, a status request is held pending and `status_go` stays 0. The flag is set by `dly_set` and cleared by `dly_release`, a SETUP or a stall. A release with a request pending pulses `status_go` on the release edge. Otherwise a status request pulses `status_go` for one cycle on the edge that ends the stage.
- R8: Packet and completion events that do not belong to the current stage, including any event other than SETUP while in stage 5, change nothing.
- R9: Response bytes are written at indices 0 to 5. `rsp_start` with length L streams min(L,6) bytes from index 0 upward, with `rsp_last` on the final byte. A length of 0 streams nothing.
- R10: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid`, `rsp_data` and `rsp_last` hold their values.
- R11: While a stream is in progress, byte writes and new starts are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| setup_vld | input | 1 | SETUP packet received |
| setup_dir_in | input | 1 | Decoded direction bit, 1 = device to host |
| setup_len | input | 16 | Decoded requested length |
| in_pkt_vld | input | 1 | IN data packet queued |
| in_pkt_last | input | 1 | The queued IN packet is the final one |
| in_cmpl | input | 1 | Completion of the final IN packet |
| out_pkt_vld | input | 1 | OUT data packet received |
| out_pkt_len | input | 16 | Byte count of the OUT packet |
| stall_req | input | 1 | Firmware stall request |
| dly_set | input | 1 | Set the delayed-status flag |
| dly_release | input | 1 | Release the delayed status stage |
| stage | output | 3 | Current stage code |
| stall_en | output | 1 | Stall handshake enable |
| status_go | output | 1 | One-cycle status-stage trigger |
| rsp_wr_en | input | 1 | Response byte write |
| rsp_wr_idx | input | 3 | Response byte index |
| rsp_wr_data | input | 8 | Response byte value |
| rsp_start | input | 1 | Start streaming the response |
| rsp_len | input | 4 | Response length in bytes |
| rsp_valid | output | 1 | Stream byte valid |
| rsp_ready | input | 1 | Stream consumer ready |
| rsp_data | output | 8 | Stream byte |
| rsp_last | output | 1 | Final stream byte |

## Verification
The bench targets the OUT stage ending in three ways: a full-size packet that exactly reaches the length, a full-size packet that overshoots it, and a short packet that arrives early. A design that compared with the wrong sense would stay stuck in stage 3 or leave it too soon. It drives a SETUP and a stall in the same cycle, and a SETUP during a stall. A wrong priority would leave the stage at 5 and block the next transfer. It releases delayed status both with and without a pending request. A design that ignored the flag would pulse early, and one that lost the pending bit would never pulse. The response stream is checked under back-pressure, with an oversize length, and with writes arriving mid-stream. Such errors would show up as repeated or skipped bytes, a seventh byte, or corrupted contents.

// File: rtl/ep0_seq_pkg.sv
package ep0_seq_pkg;
  typedef enum logic [2:0] {
    STG_IDLE   = 3'd1,
    STG_IN     = 3'd2,
    STG_OUT    = 3'd3,
    STG_IN_END = 3'd4,
    STG_HALT   = 3'd5
  } stage_e;
endpackage

// File: rtl/ep0_out_tracker.sv
module ep0_out_tracker #(
  parameter int LEN_W = 16,
  parameter int MAXP  = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] load_len,
  input  logic             accept,
  input  logic [LEN_W-1:0] pkt_len,
  output logic             pkt_ends
);
  localparam logic [LEN_W-1:0] MAXP_L = LEN_W'(MAXP);

  logic [LEN_W-1:0] rem_q;

  assign pkt_ends = (pkt_len < MAXP_L) || (pkt_len >= rem_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else if (load) begin
      rem_q <= load_len;
    end else if (accept) begin
      rem_q <= (pkt_len >= rem_q) ? '0 : rem_q - pkt_len;
    end
  end

  // R4
  rem_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> rem_q <= $past(rem_q));
endmodule

// File: rtl/ep0_status_gate.sv
module ep0_status_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic setup_clr,
  input  logic stall_clr,
  input  logic req,
  input  logic dly_set,
  input  logic dly_release,
  output logic status_go
);
  logic flag_q, pend_q, go_q;
  logic base, hold;

  always_comb begin
    base = setup_clr ? 1'b0 : flag_q;
    hold = (base | dly_set) & ~dly_release;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      pend_q <= 1'b0;
      go_q   <= 1'b0;
    end else begin
      go_q   <= (req & ~hold) |
                (dly_release & pend_q & ~setup_clr & ~stall_clr);
      flag_q <= stall_clr ? 1'b0 : hold;
      pend_q <= ((setup_clr | stall_clr) ? 1'b0 : (pend_q & ~dly_release)) |
                (req & hold);
    end
  end

  assign status_go = go_q;

  // R7
  held_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !dly_release && !setup_clr |=> !status_go);
endmodule

// File: rtl/ep0_rsp_buf.sv
module ep0_rsp_buf #(
  parameter int BYTES = 6,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [$clog2(BYTES)-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  output logic             valid,
  input  logic             ready,
  output logic [7:0]       data,
  output logic             last
);
  localparam int IW = $clog2(BYTES);
  localparam logic [LEN_W-1:0] BYTES_L = LEN_W'(BYTES);

  logic [7:0]    mem [BYTES];
  logic          busy_q;
  logic [IW-1:0] ptr_q, end_q;
  logic [LEN_W-1:0] len_c;

  assign len_c = (len > BYTES_L) ? BYTES_L : len;

  for (genvar g = 0; g < BYTES; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n) mem[g] <= '0;
      else if (wr_en && !busy_q && wr_idx == IW'(g)) mem[g] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ptr_q  <= '0;
      end_q  <= '0;
    end else if (!busy_q) begin
      if (start && len_c != '0) begin
        busy_q <= 1'b1;
        ptr_q  <= '0;
        end_q  <= IW'(len_c - 1'b1);
      end
    end else if (ready) begin
      if (ptr_q == end_q) busy_q <= 1'b0;
      else ptr_q <= ptr_q + 1'b1;
    end
  end

  assign valid = busy_q;
  assign data  = mem[ptr_q];
  assign last  = busy_q && (ptr_q == end_q);

  // R10
  stream_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready |=> valid && $stable(data) && $stable(last));
endmodule

// File: rtl/ep0_stage_fsm.sv
module ep0_stage_fsm
  import ep0_seq_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             setup_vld,
  input  logic             setup_dir_in,
  input  logic [LEN_W-1:0] setup_len,
  input  logic             in_pkt_vld,
  input  logic             in_pkt_last,
  input  logic             in_cmpl,
  input  logic             out_pkt_vld,
  input  logic             out_ends,
  input  logic             stall_req,
  output logic             out_accept,
  output logic             stat_req,
  output logic             stall_clr,
  output stage_e           stage_q
);
  stage_e nxt;

  assign stall_clr  = stall_req & ~setup_vld;
  assign out_accept = out_pkt_vld && !setup_vld && !stall_req && stage_q == STG_OUT;

  always_comb begin
    nxt      = stage_q;
    stat_req = 1'b0;
    if (setup_vld) begin
      if (setup_len == '0) begin
        nxt      = STG_IDLE;
        stat_req = 1'b1;
      end else begin
        nxt = setup_dir_in ? STG_IN : STG_OUT;
      end
    end else if (stall_req) begin
      nxt = STG_HALT;
    end else begin
      unique case (stage_q)
        STG_IN:     if (in_pkt_vld && in_pkt_last) nxt = STG_IN_END;
        STG_IN_END: if (in_cmpl) begin nxt = STG_IDLE; stat_req = 1'b1; end
        STG_OUT:    if (out_accept && out_ends) begin nxt = STG_IDLE; stat_req = 1'b1; end
        default:    nxt = stage_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stage_q <= STG_IDLE;
    else        stage_q <= nxt;
  end

  // R6
  setup_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    setup_vld |=> stage_q != STG_HALT);
  // R5
  stall_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_req && !setup_vld |=> stage_q == STG_HALT);
  // R3
  in_end_from_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stage_q == STG_IN_END && $past(stage_q) != STG_IN_END |-> $past(stage_q) == STG_IN);
  // R8
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stage_q == STG_HALT && !setup_vld |=> stage_q == STG_HALT);
endmodule

// File: rtl/ep0_stage_seq.sv
module ep0_stage_seq
  import ep0_seq_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int MAXP      = 64,
  parameter int RSP_BYTES = 6,
  parameter int RSP_LEN_W = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         setup_vld,
  input  logic                         setup_dir_in,
  input  logic [LEN_W-1:0]             setup_len,
  input  logic                         in_pkt_vld,
  input  logic                         in_pkt_last,
  input  logic                         in_cmpl,
  input  logic                         out_pkt_vld,
  input  logic [LEN_W-1:0]             out_pkt_len,
  input  logic                         stall_req,
  input  logic                         dly_set,
  input  logic                         dly_release,
  output logic [2:0]                   stage,
  output logic                         stall_en,
  output logic                         status_go,
  input  logic                         rsp_wr_en,
  input  logic [$clog2(RSP_BYTES)-1:0] rsp_wr_idx,
  input  logic [7:0]                   rsp_wr_data,
  input  logic                         rsp_start,
  input  logic [RSP_LEN_W-1:0]         rsp_len,
  output logic                         rsp_valid,
  input  logic                         rsp_ready,
  output logic [7:0]                   rsp_data,
  output logic                         rsp_last
);
  stage_e stage_q;
  logic   out_accept, out_ends, stat_req, stall_clr;

  ep0_stage_fsm #(.LEN_W(LEN_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .setup_vld(setup_vld), .setup_dir_in(setup_dir_in), .setup_len(setup_len),
    .in_pkt_vld(in_pkt_vld), .in_pkt_last(in_pkt_last), .in_cmpl(in_cmpl),
    .out_pkt_vld(out_pkt_vld), .out_ends(out_ends), .stall_req(stall_req),
    .out_accept(out_accept), .stat_req(stat_req), .stall_clr(stall_clr),
    .stage_q(stage_q)
  );

  ep0_out_tracker #(.LEN_W(LEN_W), .MAXP(MAXP)) u_trk (
    .clk(clk), .rst_n(rst_n),
    .load(setup_vld), .load_len(setup_len),
    .accept(out_accept), .pkt_len(out_pkt_len),
    .pkt_ends(out_ends)
  );

  ep0_status_gate u_gate (
    .clk(clk), .rst_n(rst_n),
    .setup_clr(setup_vld), .stall_clr(stall_clr), .req(stat_req),
    .dly_set(dly_set), .dly_release(dly_release),
    .status_go(status_go)
  );

  ep0_rsp_buf #(.BYTES(RSP_BYTES), .LEN_W(RSP_LEN_W)) u_rsp (
    .clk(clk), .rst_n(rst_n),
    .wr_en(rsp_wr_en), .wr_idx(rsp_wr_idx), .wr_data(rsp_wr_data),
    .start(rsp_start), .len(rsp_len),
    .valid(rsp_valid), .ready(rsp_ready), .data(rsp_data), .last(rsp_last)
  );

  assign stage    = stage_q;
  assign stall_en = (stage_q == STG_HALT);
endmodule

// File: tb/tb_ep0_stage_seq.sv
module tb_ep0_stage_seq;
  localparam int CLK_NS = 10;
  localparam int MAXP = 64;

  logic clk = 0, rst_n = 0;
  logic setup_vld = 0, setup_dir_in = 0;
  logic [15:0] setup_len = 0;
  logic in_pkt_vld = 0, in_pkt_last = 0, in_cmpl = 0, out_pkt_vld = 0;
  logic [15:0] out_pkt_len = 0;
  logic stall_req = 0, dly_set = 0, dly_release = 0;
  logic [2:0] stage;
  logic stall_en, status_go;
  logic rsp_wr_en = 0, rsp_start = 0, rsp_ready = 0;
  logic [2:0] rsp_wr_idx = 0;
  logic [7:0] rsp_wr_data = 0;
  logic [3:0] rsp_len = 0;
  logic rsp_valid, rsp_last;
  logic [7:0] rsp_data;

  int total = 0, bad = 0;
  int m_stage = 1, m_rem = 0;
  bit m_flag = 0, m_pend = 0, m_go = 0;

  ep0_stage_seq dut (.*);

  always #(CLK_NS/2) clk = ~clk;

  task automatic chk(string r, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  // reference behaviour computed from the requirements
  task automatic model_step();
    bit req = 0, hold, s = setup_vld, st = stall_req;
    if (s) begin
      m_rem = setup_len;
      if (setup_len == 0) begin m_stage = 1; req = 1; end
      else m_stage = setup_dir_in ? 2 : 3;
    end else if (st) m_stage = 5;
    else begin
      case (m_stage)
        2: if (in_pkt_vld && in_pkt_last) m_stage = 4;
        4: if (in_cmpl) begin m_stage = 1; req = 1; end
        3: if (out_pkt_vld) begin
             if (out_pkt_len < MAXP || out_pkt_len >= m_rem) begin m_stage = 1; req = 1; end
             m_rem = (out_pkt_len >= m_rem) ? 0 : m_rem - out_pkt_len;
           end
        default: ;
      endcase
    end
    hold = ((s ? 1'b0 : m_flag) | dly_set) & ~dly_release;
    m_go = (req && !hold) || (dly_release && m_pend && !s && !st);
    m_pend = ((s || st) ? 1'b0 : (m_pend && !dly_release)) || (req && hold);
    m_flag = (!s && st) ? 1'b0 : hold;
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst_n) model_step();
    #1;
    if (rst_n) begin
      chk("R2/R8 stage", stage, m_stage);
      chk("R7 status_go", status_go, m_go);
      chk("R5 stall_en", stall_en, m_stage == 5);
    end
    setup_vld = 0; in_pkt_vld = 0; in_pkt_last = 0; in_cmpl = 0;
    out_pkt_vld = 0; stall_req = 0; dly_set = 0; dly_release = 0;
    rsp_wr_en = 0; rsp_start = 0;
  endtask

  task automatic do_setup(bit dir, int len);
    setup_vld = 1; setup_dir_in = dir; setup_len = 16'(len); tick();
  endtask

  task automatic do_out(int len);
    out_pkt_vld = 1; out_pkt_len = 16'(len); tick();
  endtask

  task automatic pull(int n, int base, string r);
    for (int k = 0; k < n; k++) begin
      chk({r, " valid"}, rsp_valid, 1);
      chk({r, " data"}, rsp_data, base + k);
      chk({r, " last"}, rsp_last, k == n - 1);
      rsp_ready = 1; tick(); rsp_ready = 0;
    end
    chk({r, " done"}, rsp_valid, 0);
  endtask

  initial begin
    int watchdog_hit = 0;
    fork
      begin : body
        void'($urandom(32'h5eed));
        repeat (3) tick();
        rst_n = 1;
        #1;
        // R1 reset values
        chk("R1 stage", stage, 1);
        chk("R1 stall_en", stall_en, 0);
        chk("R1 status_go", status_go, 0);
        chk("R1 rsp_valid", rsp_valid, 0);

        // R2 / R3 IN path
        do_setup(1, 10);           chk("R2 in stage", stage, 2);
        in_pkt_vld = 1; tick();    chk("R3 not last", stage, 2);
        in_cmpl = 1; tick();       chk("R8 cmpl in TX ignored", stage, 2);
        in_pkt_vld = 1; in_pkt_last = 1; tick(); chk("R3 last", stage, 4);
        in_cmpl = 1; tick();       chk("R3 cmpl", stage, 1); chk("R3 go", status_go, 1);
        tick();                    chk("R7 one pulse", status_go, 0);

        // R4 OUT: exact reach, overshoot, short
        do_setup(0, 128);          chk("R2 out stage", stage, 3);
        do_out(64);                chk("R4 partial", stage, 3);
        do_out(64);                chk("R4 reach", stage, 1); chk("R4 go", status_go, 1);
        do_setup(0, 100);
        do_out(64); do_out(64);    chk("R4 overshoot", stage, 1);
        do_setup(0, 300);
        do_out(10);                chk("R4 short", stage, 1);
        do_setup(0, 0);            chk("R2 zero len", stage, 1); chk("R2 zero go", status_go, 1);

        // R5 / R6 / R8 stall
        do_setup(0, 200);
        stall_req = 1; tick();     chk("R5 stall", stage, 5); chk("R5 en", stall_en, 1);
        do_out(5);                 chk("R8 out in stall", stage, 5);
        in_cmpl = 1; tick();       chk("R8 cmpl in stall", stage, 5);
        setup_vld = 1; setup_dir_in = 1; setup_len = 4; stall_req = 1; tick();
        chk("R6 setup beats stall", stage, 2);
        do_setup(0, 0);            chk("R6 abort", stage, 1);

        // R7 delayed status
        dly_set = 1; setup_vld = 1; setup_len = 0; tick();
        chk("R7 held", status_go, 0);
        tick(); tick();            chk("R7 still held", status_go, 0);
        dly_release = 1; tick();   chk("R7 release", status_go, 1);
        tick();
        dly_set = 1; tick();
        dly_release = 1; tick();   chk("R7 release no pend", status_go, 0);

        // R9 / R10 / R11 response stream
        for (int i = 0; i < 6; i++) begin
          rsp_wr_en = 1; rsp_wr_idx = 3'(i); rsp_wr_data = 8'(8'hA0 + i); tick();
        end
        rsp_start = 1; rsp_len = 2; tick();
        chk("R10 first", rsp_data, 8'hA0);
        tick();                    chk("R10 hold data", rsp_data, 8'hA0);
        chk("R10 hold valid", rsp_valid, 1);
        rsp_wr_en = 1; rsp_wr_idx = 1; rsp_wr_data = 8'h55; rsp_start = 1; rsp_len = 6; tick();
        pull(2, 8'hA0, "R9 len2");
        chk("R11 no restart", rsp_valid, 0);
        rsp_start = 1; rsp_len = 9; tick();
        pull(6, 8'hA0, "R11 R9 clamp");
        rsp_start = 1; rsp_len = 0; tick();
        chk("R9 len0", rsp_valid, 0);

        // random traffic checked against the model
        for (int n = 0; n < 4000; n++) begin
          int r = $urandom % 100;
          if (r < 7) begin
            setup_vld = 1; setup_dir_in = 1'($urandom);
            setup_len = ($urandom % 4 == 0) ? 16'd0 : 16'($urandom % 300 + 1);
          end
          if ($urandom % 100 < 15) begin in_pkt_vld = 1; in_pkt_last = ($urandom % 5 < 2); end
          if ($urandom % 100 < 12) in_cmpl = 1;
          if ($urandom % 100 < 25) begin
            out_pkt_vld = 1;
            out_pkt_len = ($urandom % 3 == 0) ? 16'($urandom % MAXP) : 16'(MAXP);
          end
          if ($urandom % 100 < 2) stall_req = 1;
          if ($urandom % 100 < 5) dly_set = 1;
          if ($urandom % 100 < 7) dly_release = 1;
          tick();
        end
        disable wd;
      end
      begin : wd
        repeat (150000) @(posedge clk);
        watchdog_hit = 1;
        disable body;
      end
    join
    if (watchdog_hit) begin
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule